// File: doc/BRIEF.md
# Reloadable Nibble-Bus Timer

An 8-bit up-counter with automatic reload. A small controller reaches it over a 4-bit register bus with a 2-bit address and separate read and write strobes. The counter advances on pulses from a power-of-two prescaler. The prescaler is fed either by the system clock divided by four or by chosen transitions on an external pin. The external pin is first resynchronised to the system clock. When the count wraps past its top value, the counter reloads itself from a write-only reload value and raises a sticky interrupt request.

Because the bus is four bits wide, both directions follow a fixed nibble order so that an 8-bit quantity moves as one unit. Software stages the low half of the reload value first, and the write of the high half commits both halves at once. On reads, the high half comes first and freezes the low half, so the two reads describe a single instant of the count.

Top module: `nibble_timer`

## Requirements
- R1: After reset the count, reload value, staged low nibble, mode code, source bit, edge bit and interrupt request are all zero.
- R2: A write to address 0 only stages the low reload nibble, and the count does not change.
- R3: A write to address 1 places {written nibble, staged low nibble} into both the count and the reload value in the same cycle, and restarts the prescaler.
- R4: A read of address 1 returns count[7:4] and captures count[3:0]. A later read of address 0 returns that captured nibble, even if the count has moved on since.
- R5: When a count pulse arrives while the count is 0xFF, the count takes the reload value and the interrupt request sets.
- R6: The interrupt request (output irq_req, also control bit 3 on reads of address 3) stays set until a write to address 3 with data bit 3 at 1 clears it.
- R7: With source bit (address 3, bit 1) at 0 and mode code 111, the count advances once every 4 clocks, first on the 4th clock after the high-nibble write. Without a count pulse it holds.
- R8: With source bit 1 and edge bit (address 3, bit 0) at 0, only low-to-high transitions of the synchronised pin feed the prescaler.
- R9: With source bit 1 and edge bit 1, only high-to-low transitions of the pin feed the prescaler.
- R10: The 3-bit mode code at address 2 (bits 2:0, read back with bit 3 at 0) selects the ratio 000:/2048, 001:/512, 010:/128, 011:/32, 100:/8, 101:/4, 110:/2, 111:/1. A mode write restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 count low, 1 count high, 2 mode, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble, valid while bus_rd is high |
| ext_pin | input | 1 | Asynchronous external event input |
| irq_req | output | 1 | Sticky overflow interrupt request |

## Verification
The counting path is driven in three ways. The divided system clock, with its exact 4-cycle cadence, separates a correct divider from a faster or slower one. A single rising and a single falling pin pulse, under each edge setting, show whether the wrong edge is counted or both edges are. Trains of pin pulses under the /2, /8 and /32 codes (31 then 32 pulses for /32) expose a wrong ratio mapping or an off-by-one in the prescaler. A wrap from 0xFE, observed after the counter is frozen by switching to a quiet pin, separates reload from a plain wrap to zero. A read pair taken while the count moves shows whether the low nibble really comes from the latch.

// File: rtl/nibble_timer.sv
module nibble_timer #(
  parameter int PRE_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       ext_pin,
  output logic       irq_req
);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_MODE = 2'd2, A_CTL = 2'd3;

  logic [7:0]       count, reload;
  logic [3:0]       stage_lo, rd_lo;
  logic [2:0]       mode;
  logic             src_sel, edge_sel, irq;
  logic [2:0]       sync;
  logic [1:0]       div;
  logic [PRE_W-1:0] pre, mask;
  int               shift;

  wire wr_lo   = bus_wr && bus_addr == A_LO;
  wire wr_hi   = bus_wr && bus_addr == A_HI;
  wire wr_mode = bus_wr && bus_addr == A_MODE;
  wire wr_ctl  = bus_wr && bus_addr == A_CTL;

  wire ext_rise  = sync[1] & ~sync[2];
  wire ext_fall  = ~sync[1] & sync[2];
  wire ext_edge  = edge_sel ? ext_fall : ext_rise;
  wire base_tick = src_sel ? ext_edge : (div == 2'd3);
  wire cnt_en    = base_tick && ((pre & mask) == mask);
  wire wrap      = cnt_en && !wr_hi && count == 8'hFF;

  always_comb begin
    case (mode)
      3'b000:  shift = 11;
      3'b001:  shift = 9;
      3'b010:  shift = 7;
      3'b011:  shift = 5;
      3'b100:  shift = 3;
      3'b101:  shift = 2;
      3'b110:  shift = 1;
      default: shift = 0;
    endcase
    mask = PRE_W'((32'd1 << shift) - 32'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      div  <= '0;
      pre  <= '0;
    end else begin
      sync <= {sync[1:0], ext_pin};
      if (wr_hi || wr_mode) begin
        div <= '0;
        pre <= '0;
      end else begin
        div <= div + 2'd1;
        if (base_tick) pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      reload   <= '0;
      stage_lo <= '0;
      rd_lo    <= '0;
      mode     <= '0;
      src_sel  <= 1'b0;
      edge_sel <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_lo) stage_lo <= bus_wdata;
      if (wr_mode) mode <= bus_wdata[2:0];
      if (wr_ctl) begin
        edge_sel <= bus_wdata[0];
        src_sel  <= bus_wdata[1];
      end
      if (bus_rd && bus_addr == A_HI) rd_lo <= count[3:0];
      if (wr_hi) begin
        count  <= {bus_wdata, stage_lo};
        reload <= {bus_wdata, stage_lo};
      end else if (cnt_en) begin
        count <= (count == 8'hFF) ? reload : count + 8'd1;
      end
      if (wrap) irq <= 1'b1;
      else if (wr_ctl && bus_wdata[3]) irq <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 4'h0;
    if (bus_rd) begin
      case (bus_addr)
        A_LO:    bus_rdata = rd_lo;
        A_HI:    bus_rdata = count[7:4];
        A_MODE:  bus_rdata = {1'b0, mode};
        default: bus_rdata = {irq, 1'b0, src_sel, edge_sel};
      endcase
    end
  end

  assign irq_req = irq;

  assert_hi_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (count == {$past(bus_wdata), $past(stage_lo)}) && (reload == count));

  assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == $past(reload)) && irq_req);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !(wr_ctl && bus_wdata[3])) |=> irq_req);

  assert_hold_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !cnt_en) |=> $stable(count));

  assert_single_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);

  assert_mode_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mode == $past(bus_wdata[2:0]));
endmodule

// File: tb/nibble_timer_bench.sv
module nibble_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       irq_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  nibble_timer u_nibble_timer (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .irq_req(irq_req));

  always #5 clk = ~clk;

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(posedge clk); #2; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [3:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #2; bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #2; bus_rd = 1'b0;
  endtask

  task automatic rd_count(input logic [7:0] e, input string tag);
    rd(2'd1, e[7:4], tag);
    rd(2'd0, e[3:0], tag);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; ext_pin = 1'b1;
      repeat (2) @(posedge clk); #2; ext_pin = 1'b0;
      repeat (2) @(posedge clk);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic check_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq_req !== e) begin
      errors++;
      $display("FAIL %s irq_req actual %0b expected %0b", tag, irq_req, e);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rd) begin
      logic [3:0] e;
      string t;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor unexpected read actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd_count(8'h00, "R1 count");
    rd(2'd2, 4'h0, "R1 mode");
    rd(2'd3, 4'h0, "R1 control");
    check_irq(1'b0, "R1 irq");

    // R2 low nibble only stages
    wr(2'd0, 4'h5);
    rd_count(8'h00, "R2 count unchanged");
    // R3 high nibble commits
    wr(2'd1, 4'hA);
    rd_count(8'hA5, "R3 loaded");
    rd(2'd3, 4'h0, "R3 no irq");

    // R10 mode read back
    wr(2'd2, 4'h7);
    rd(2'd2, 4'h7, "R10 mode 111");

    // R4 latch while counting (div4, /1)
    wr(2'd0, 4'hE);
    wr(2'd1, 4'h0);          // count 0E, next steps at +4,+8,+12
    rd(2'd1, 4'h0, "R4 high");
    repeat (12) @(posedge clk);
    rd(2'd0, 4'hE, "R4 latched low");

    // R7 cadence: load 20, freeze at commit+42 -> 2A
    wr(2'd0, 4'h0);
    wr(2'd1, 4'h2);
    repeat (40) @(posedge clk);
    wr(2'd3, 4'h2);          // quiet pin source freezes count
    rd_count(8'h2A, "R7 four-clock cadence");
    repeat (30) @(posedge clk);
    rd_count(8'h2A, "R7 holds without pulses");

    // R5 wrap from FE: FF at +4, reload FE at +8, freeze at +10
    wr(2'd3, 4'h0);
    wr(2'd0, 4'hE);
    wr(2'd1, 4'hF);
    repeat (8) @(posedge clk);
    wr(2'd3, 4'h2);
    rd_count(8'hFE, "R5 reloaded");
    rd(2'd3, 4'hA, "R5 irq set");

    // R6 sticky then clear
    repeat (50) @(posedge clk);
    check_irq(1'b1, "R6 sticky");
    wr(2'd3, 4'hA);          // bit3 clears, keep external source
    check_irq(1'b0, "R6 cleared");
    rd(2'd3, 4'h2, "R6 control after clear");
    rd_count(8'hFE, "R6 count untouched");

    // R8 rising edges only
    wr(2'd2, 4'h7);
    wr(2'd0, 4'h0);
    wr(2'd1, 4'h1);
    @(posedge clk); #2 ext_pin = 1'b1;
    repeat (6) @(posedge clk);
    rd_count(8'h11, "R8 rise counted");
    #1 ext_pin = 1'b0;
    repeat (6) @(posedge clk);
    rd_count(8'h11, "R8 fall ignored");

    // R9 falling edges only
    wr(2'd3, 4'h3);
    @(posedge clk); #2 ext_pin = 1'b1;
    repeat (6) @(posedge clk);
    rd_count(8'h11, "R9 rise ignored");
    #1 ext_pin = 1'b0;
    repeat (6) @(posedge clk);
    rd_count(8'h12, "R9 fall counted");

    // R10 ratios with external pulses (rising)
    wr(2'd3, 4'h2);
    wr(2'd2, 4'h6);          // /2
    wr(2'd0, 4'h0);
    wr(2'd1, 4'h4);
    pulses(4);
    rd_count(8'h42, "R10 /2");
    wr(2'd2, 4'h4);          // /8
    wr(2'd1, 4'h5);
    pulses(8);
    rd_count(8'h51, "R10 /8");
    wr(2'd2, 4'h3);          // /32
    wr(2'd1, 4'h6);
    pulses(31);
    rd_count(8'h60, "R10 /32 31 pulses");
    pulses(1);
    rd_count(8'h61, "R10 /32 32 pulses");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL monitor pending actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule